// File: doc/BRIEF.md
# Startup Sequencer with Shared DONE Handshake

After a programmable device has taken in its configuration data, this block runs it through the startup steps. It counts through eight numbered steps. At chosen steps it lets go of the DONE line and releases the three global controls: the output tristate (`gts`), the set/reset (`gsr`) and the write enable (`gwe`). DONE is an open-drain line that other devices in a chain also pull on. The block therefore reads the line level back through a synchronizer and waits at its DONE step until every device on the line has let go.

Each global control takes a 4-bit selection. If its flag bit is clear, the control changes at a fixed step. If the flag bit is set, the control changes on the step where the shared DONE line is seen high. With the drive option set, the block also drives DONE high after release, which is only suitable for the last device on a line. A `release_done` status output shows whether this device has let go of DONE, so capture or status logic elsewhere can read it.

Top module: `startup_seq`

## Requirements
- R1: While `rst` is high, and until the sequence starts, `done_pull_low`=1, `gts`=1, `gsr`=1, `gwe`=0, `done_drive_hi`=0, `release_done`=0 and `eos`=0.
- R2: While `cfg_loaded` is low after reset, no output changes. On the clock edge that samples `cfg_loaded` high, the block enters step 0. Each later edge handles the current step and advances by one, except during a stall.
- R3: A control whose selection has bit 3 clear and cycle field bits [2:0]=c changes on the edge that handles step c (`gts` and `gsr` fall, `gwe` rises) and keeps that value.
- R4: On the edge that handles step `done_cyc`, `done_pull_low` falls and `release_done` rises. Both keep their new value until reset.
- R5: The block stays at step `done_cyc` until the `done_pad_in` level, passed through two flops, reads high. If the pad first reads high after edge P, the step is left on edge P+3.
- R6: A fixed selection with c below or equal to `done_cyc` takes effect on schedule and is not held back by the DONE stall.
- R7: A control whose selection has bit 3 set changes on the edge where the block leaves step `done_cyc` with the synchronized DONE high.
- R8: With `drive_done`=1, `done_drive_hi` rises on the same edge as the DONE release. With `drive_done`=0 it stays low.
- R9: `eos` rises on the edge that handles step 7 and stays high. At that point `gts`=0, `gsr`=0 and `gwe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_loaded | input | 1 | Configuration data is in place; start the steps |
| done_cyc | input | 3 | Step at which DONE is released |
| gts_sel | input | 4 | Tristate release: bit 3 = follow DONE, bits 2:0 = step |
| gsr_sel | input | 4 | Set/reset release: same encoding |
| gwe_sel | input | 4 | Write-enable release: same encoding |
| drive_done | input | 1 | Actively drive DONE high once released |
| done_pad_in | input | 1 | Sensed level of the shared DONE line |
| done_pull_low | output | 1 | Enables the DONE pull-down |
| done_drive_hi | output | 1 | Enables the active high drive on DONE |
| gts | output | 1 | Global tristate, high while outputs are held off |
| gsr | output | 1 | Global set/reset, high while held |
| gwe | output | 1 | Global write enable |
| release_done | output | 1 | This device has let go of DONE |
| eos | output | 1 | Startup finished |

## Verification
The bench uses the default parameters: a 3-bit step number (eight steps) and a two-stage synchronizer. With these values, the DONE step can be placed at step 0 and at step 7, so both the first and the last step are covered. The three-edge wait after the pad rises is short enough to predict exactly. An external hold on the line, longer than the block's own release time, shows the stall directly: the timing of every DONE-tied control and of `eos` shifts by the length of the hold, while the earlier fixed releases do not move.

// File: rtl/startup_pkg.sv
package startup_pkg;
    localparam int unsigned CYC_W     = 3;
    localparam int unsigned SEL_W     = CYC_W + 1;
    localparam int unsigned NUM_STEPS = 1 << CYC_W;

    typedef logic [CYC_W-1:0] step_t;

    typedef struct packed {
        logic  on_done;
        step_t cyc;
    } rel_sel_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_END  = 2'd2
    } seq_state_t;

    localparam step_t LAST_STEP = step_t'(NUM_STEPS - 1);

    // Release condition for one global control in the current step.
    function automatic logic sel_fires(rel_sel_t sel, step_t step, logic running,
                                       logic leave_done_step);
        if (!running)
            return 1'b0;
        if (sel.on_done)
            return leave_done_step;
        return step == sel.cyc;
    endfunction
endpackage

// File: rtl/done_sync.sv
module done_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    output logic level_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], pad_in};
    end

    assign level_out = chain_q[STAGES-1];
endmodule

// File: rtl/startup_ctrl.sv
module startup_ctrl
    import startup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_loaded,
    input  step_t      done_cyc,
    input  logic       done_seen,
    output logic       running,
    output step_t      step,
    output logic       at_done_step,
    output logic       leave_done_step,
    output logic       finished
);
    seq_state_t state_q;
    step_t      step_q;
    logic       stall;

    assign running         = (state_q == SQ_RUN);
    assign at_done_step    = running && (step_q == done_cyc);
    assign stall           = at_done_step && !done_seen;
    assign leave_done_step = at_done_step && done_seen;
    assign step            = step_q;
    assign finished        = (state_q == SQ_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (cfg_loaded) begin
                    state_q <= SQ_RUN;
                    step_q  <= '0;
                end
                SQ_RUN: if (!stall) begin
                    if (step_q == LAST_STEP)
                        state_q <= SQ_END;
                    else
                        step_q <= step_q + step_t'(1);
                end
                default: state_q <= SQ_END;
            endcase
        end
    end

    // R5: while the line is unseen the step holds
    a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (running && step_q == done_cyc && !done_seen) |=> (running && step_q == $past(step_q)));

    // R2: steps advance one per edge outside a stall
    a_r2_step_advance: assert property (@(posedge clk) disable iff (rst)
        (running && !(step_q == done_cyc && !done_seen) && step_q != LAST_STEP)
            |=> (step_q == $past(step_q) + step_t'(1)));

    // R2: nothing starts without the loaded flag
    a_r2_idle_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && !cfg_loaded) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/release_flag.sv
module release_flag
    import startup_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rel_sel_t sel,
    input  step_t    step,
    input  logic     running,
    input  logic     leave_done_step,
    output logic     released
);
    logic rel_q;

    always_ff @(posedge clk) begin
        if (rst)
            rel_q <= 1'b0;
        else if (sel_fires(sel, step, running, leave_done_step))
            rel_q <= 1'b1;
    end

    assign released = rel_q;

    // R3: a release never reverts
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        rel_q |=> rel_q);
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_loaded,
    input  logic [CYC_W-1:0] done_cyc,
    input  logic [SEL_W-1:0] gts_sel,
    input  logic [SEL_W-1:0] gsr_sel,
    input  logic [SEL_W-1:0] gwe_sel,
    input  logic             drive_done,
    input  logic             done_pad_in,
    output logic             done_pull_low,
    output logic             done_drive_hi,
    output logic             gts,
    output logic             gsr,
    output logic             gwe,
    output logic             release_done,
    output logic             eos
);
    localparam int unsigned NUM_CTRL = 3;

    logic     done_seen;
    logic     running, at_done_step, leave_done_step, finished;
    step_t    step;
    logic     done_rel_q;
    rel_sel_t sel_arr [NUM_CTRL];
    logic [NUM_CTRL-1:0] ctrl_rel;

    assign sel_arr[0] = rel_sel_t'(gts_sel);
    assign sel_arr[1] = rel_sel_t'(gsr_sel);
    assign sel_arr[2] = rel_sel_t'(gwe_sel);

    done_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .pad_in(done_pad_in), .level_out(done_seen)
    );

    startup_ctrl ctrl_i (
        .clk(clk), .rst(rst), .cfg_loaded(cfg_loaded), .done_cyc(done_cyc),
        .done_seen(done_seen), .running(running), .step(step),
        .at_done_step(at_done_step), .leave_done_step(leave_done_step),
        .finished(finished)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        release_flag rel_i (
            .clk(clk), .rst(rst), .sel(sel_arr[g]), .step(step),
            .running(running), .leave_done_step(leave_done_step),
            .released(ctrl_rel[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            done_rel_q <= 1'b0;
        else if (at_done_step)
            done_rel_q <= 1'b1;
    end

    assign done_pull_low = !done_rel_q;
    assign done_drive_hi = done_rel_q && drive_done;
    assign release_done  = done_rel_q;
    assign gts           = !ctrl_rel[0];
    assign gsr           = !ctrl_rel[1];
    assign gwe           = ctrl_rel[2];
    assign eos           = finished;

    // R8: active drive only after the pull-down is off
    a_r8_drive_after_release: assert property (@(posedge clk) disable iff (rst)
        done_drive_hi |-> !done_pull_low);

    // R4: once let go, DONE stays released
    a_r4_release_sticky: assert property (@(posedge clk) disable iff (rst)
        !done_pull_low |=> !done_pull_low);

    // R9: finished implies every control released
    a_r9_end_state: assert property (@(posedge clk) disable iff (rst)
        eos |-> (gwe && !gts && !gsr && !done_pull_low));

    // R5: the sequence cannot pass DONE's step before the line reads high
    a_r5_no_pass_unseen: assert property (@(posedge clk) disable iff (rst)
        $rose(eos) |-> $past(done_seen));
endmodule

// File: tb/startup_seq_tb.sv
module startup_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_loaded = 1'b0;
    logic [2:0] done_cyc = '0;
    logic [3:0] gts_sel = '0, gsr_sel = '0, gwe_sel = '0;
    logic       drive_done = 1'b0;
    logic       ext_hold = 1'b1;
    logic       done_pad_in;
    logic       done_pull_low, done_drive_hi, gts, gsr, gwe, release_done, eos;

    always #2 clk = ~clk;

    // wired-AND line with pull-up
    assign done_pad_in = !done_pull_low && !ext_hold;

    startup_seq dut_i (
        .clk(clk), .rst(rst), .cfg_loaded(cfg_loaded), .done_cyc(done_cyc),
        .gts_sel(gts_sel), .gsr_sel(gsr_sel), .gwe_sel(gwe_sel),
        .drive_done(drive_done), .done_pad_in(done_pad_in),
        .done_pull_low(done_pull_low), .done_drive_hi(done_drive_hi),
        .gts(gts), .gsr(gsr), .gwe(gwe), .release_done(release_done), .eos(eos)
    );

    typedef struct {
        int    id;
        int    edge_n;
        string req;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  n_tests = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  base = 1 << 30;
    bit  mon_en = 0;
    logic [5:0] prev_v = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: ids 0 done released,1 gts,2 gsr,3 gwe,4 drive,5 eos
    always @(negedge clk) begin
        logic [5:0] cur;
        cur = {eos, done_drive_hi, gwe, gsr, gts, done_pull_low};
        if (mon_en) begin
            for (int i = 0; i < 6; i++) begin
                if (cur[i] !== prev_v[i]) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R2", $sformatf("unexpected change id%0d", i), cyc - base, -1);
                    end else begin
                        exp_item_t it;
                        it = exp_q.pop_front();
                        check(it.id == i, it.req, "change order id", i, it.id);
                        check(it.edge_n == cyc - base, it.req,
                              $sformatf("edge of id%0d", i), cyc - base, it.edge_n);
                    end
                end
            end
        end
        prev_v = cur;
    end

    function automatic int sel_edge(input logic [3:0] s, input int d, input int p);
        int c;
        c = int'(s[2:0]);
        if (s[3]) return p + 3;
        if (c <= d) return c + 1;
        return p + 3 + (c - d);
    endfunction

    function automatic string sel_req(input logic [3:0] s, input int d);
        if (s[3]) return "R7";
        if (int'(s[2:0]) <= d) return "R6";
        return "R3";
    endfunction

    task automatic run_scn(input int d, input logic [3:0] gs, input logic [3:0] rs,
                           input logic [3:0] ws, input logic drv, input int hold);
        int ex [6];
        string rq [6];
        int t, p, last;
        rst = 1'b1; mon_en = 0; ext_hold = 1'b1; cfg_loaded = 1'b0;
        done_cyc = 3'(d); gts_sel = gs; gsr_sel = rs; gwe_sel = ws; drive_done = drv;
        repeat (3) @(negedge clk);
        check(done_pull_low && gts && gsr && !gwe && !done_drive_hi && !release_done && !eos,
              "R1", "state in reset", {done_pull_low, gts, gsr, gwe, eos}, 5'b11100);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(done_pull_low && gts && gsr && !gwe && !release_done && !eos,
              "R2", "idle without cfg_loaded", {done_pull_low, gts, gsr, gwe, eos}, 5'b11100);
        t = d + 1;
        p = (hold > t) ? hold : t;
        ex[0] = t;                 rq[0] = "R4";
        ex[1] = sel_edge(gs, d, p); rq[1] = sel_req(gs, d);
        ex[2] = sel_edge(rs, d, p); rq[2] = sel_req(rs, d);
        ex[3] = sel_edge(ws, d, p); rq[3] = sel_req(ws, d);
        ex[4] = drv ? t : -1;      rq[4] = "R8";
        ex[5] = p + 3 + (7 - d);   rq[5] = (d == 7) ? "R5" : "R9";
        last = ex[5];
        for (int e = 0; e <= last; e++)
            for (int i = 0; i < 6; i++)
                if (ex[i] == e) exp_q.push_back('{i, e, rq[i]});
        mon_en = 1;
        cfg_loaded = 1'b1;
        base = cyc + 1;
        do begin
            @(negedge clk);
            if (cyc - base >= hold) ext_hold = 1'b0;
        end while (cyc - base < last + 3);
        mon_en = 0;
        check(exp_q.size() == 0, "R9", "events missing", exp_q.size(), 0);
        exp_q.delete();
        check(release_done == 1'b1, "R4", "release_done at end", release_done, 1);
        check(done_drive_hi == drv, "R8", "drive state at end", done_drive_hi, drv);
        check(eos && gwe && !gts && !gsr, "R9", "final state", {eos, gwe, gts, gsr}, 4'b1100);
    endtask

    initial begin
        // DONE at step 0, later fixed steps
        run_scn(0, 4'b0001, 4'b0010, 4'b0011, 1'b0, 0);
        // early GTS, GSR/GWE tied to DONE, line held externally
        run_scn(3, 4'b0000, 4'b1000, 4'b1000, 1'b0, 12);
        // GTS same step as DONE, drive option on
        run_scn(2, 4'b0010, 4'b0001, 4'b0110, 1'b1, 0);
        // DONE on last step, all controls tied to DONE, long hold
        run_scn(7, 4'b1000, 4'b1000, 4'b1000, 1'b1, 20);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule